// File: doc/BRIEF.md
# Conditional Instruction Class Decoder

This block sits at the front of an instruction decode stage. Each cycle it takes one 32-bit instruction word and the four current status flags (negative, zero, carry, overflow). One cycle later it reports four things about that word: which of fourteen instruction classes it belongs to, whether its condition field is satisfied by the flags, whether that field holds the reserved code, and whether the word must raise an undefined-instruction trap. A small variant field carries the one to three mode bits that later stages need in order to steer the chosen class.

Several encodings overlap in the low region of the opcode space, where the top bits 27:26 are 00. The decoder resolves them in a fixed priority, from the narrowest pattern to the broadest. One multiply-shaped gap is left deliberately unassigned. A word in that gap gets no class and no trap, so it is neither executed nor trapped. A valid strobe qualifies the input. When it is low, every class bit and the trap go to zero on the next cycle.

Top module: `cond_class_decode`

## Requirements
- R1: Outputs are registered. The result for a word presented with `valid_i` high appears on the outputs after the next rising clock edge, and `valid_o` then equals the `valid_i` sampled at that edge.
- R2: For a cycle where `valid_i` was low, the next cycle shows `class_o`, `cond_pass_o`, `cond_rsvd_o`, `undef_trap_o` and `variant_o` all zero. Reset gives the same all-zero state.
- R3: The condition field is bits 31:28 and the flags are `flags_i` = {N,Z,C,V}. The field passes under these rules:
  - 0000: Z=1. 0001: Z=0.
  - 0010: C=1. 0011: C=0.
  - 0100: N=1. 0101: N=0.
  - 0110: V=1. 0111: V=0.
  - 1000: C=1 and Z=0. 1001: C=0 or Z=1.
  - 1010: N==V. 1011: N!=V.
  - 1100: Z=0 and N==V. 1101: Z=1 or N!=V.
  - 1110: always passes.
- R4: Condition code 1111 sets `cond_rsvd_o` and never sets `cond_pass_o`. Every other code leaves `cond_rsvd_o` low.
- R5: `class_o` has at most one bit set. The bit indices are:
  - 0 data processing, 1 multiply, 2 multiply long, 3 swap
  - 4 branch-exchange, 5 halfword transfer, 6 single transfer, 7 undefined
  - 8 block transfer, 9 branch
  - 10 coprocessor transfer, 11 coprocessor data op, 12 coprocessor register transfer
  - 13 software interrupt
- R6: The branch-exchange class (bit 4) is chosen when bits 27:4 equal 0x12FFF1. This check comes before every other class.
- R7: The swap class (bit 3) is chosen when bits 27:23=00010, bits 21:20=00 and bits 11:4=0x09. Otherwise, with bits 7:4=1001, the multiply class (bit 1) is chosen for bits 27:22=000000, and the multiply-long class (bit 2) for bits 27:23=00001.
- R8: A word with bits 27:24=0000 and bits 7:4=1101 that none of the above matched gets no class bit and no trap.
- R9: The halfword class (bit 5) is chosen for any remaining word that has bits 27:25=000, bit 7=1 and bit 4=1, provided either bit 22=1 (immediate offset) or bits 11:8=0000 (register offset).
- R10: Any other word with bits 27:26=00 falls into the data-processing class (bit 0).
- R11: The remaining words are classified by bits 27:24 as follows:
  - 011x with bit 4=1: undefined (bit 7).
  - Any other 01xx: single transfer (bit 6).
  - 100x: block transfer (bit 8).
  - 101x: branch (bit 9).
  - 110x: coprocessor transfer (bit 10).
  - 1110 with bit 4=0: coprocessor data op (bit 11).
  - 1110 with bit 4=1: coprocessor register transfer (bit 12).
  - 1111: software interrupt (bit 13).
- R12: `undef_trap_o` is high exactly when the undefined class is reported and the condition passes.
- R13: `variant_o` depends on the class:
  - Halfword: {bit 22, bit 6, bit 5}, which is {immediate, signed, half}.
  - Swap: {0,0,bit 22}, the byte flag.
  - Branch: {0,0,bit 24}, the link flag.
  - Any other class: zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `insn_i` and `flags_i` |
| insn_i | input | 32 | Instruction word |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| valid_o | output | 1 | Registered valid |
| class_o | output | 14 | One-hot instruction class |
| cond_pass_o | output | 1 | Condition field satisfied |
| cond_rsvd_o | output | 1 | Condition field holds reserved code 1111 |
| undef_trap_o | output | 1 | Undefined-instruction trap request |
| variant_o | output | 3 | Class mode bits |

## Verification
The hardest situations to reach are the overlaps in the bits 27:26=00 region. There, one word can fit the swap, multiply, halfword, unassigned-gap and data-processing shapes at once, and only the priority order tells them apart. The stimulus sweeps every value of bits 27:20 against every value of bits 7:4. It does this under three fillers for the remaining bits. One filler completes the branch-exchange pattern. One zeroes bits 11:8, which admits the register-offset halfword and swap forms. One leaves bits 11:8 nonzero, which pushes those words down to data processing. The condition code and flags rotate along with the sweep, so the trap is also exercised with and without a passing condition.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    localparam int INSN_W  = 32;
    localparam int FLAG_W  = 4;
    localparam int COND_W  = 4;
    localparam int BODY_W  = INSN_W - COND_W;
    localparam int CLS_N   = 14;
    localparam int VAR_W   = 3;

    localparam int CL_DP    = 0;
    localparam int CL_MUL   = 1;
    localparam int CL_MULL  = 2;
    localparam int CL_SWAP  = 3;
    localparam int CL_BX    = 4;
    localparam int CL_HALF  = 5;
    localparam int CL_SXFR  = 6;
    localparam int CL_UNDEF = 7;
    localparam int CL_BLK   = 8;
    localparam int CL_BR    = 9;
    localparam int CL_CPX   = 10;
    localparam int CL_CPD   = 11;
    localparam int CL_CPR   = 12;
    localparam int CL_SWI   = 13;

    localparam logic [COND_W-1:0] COND_RSVD = 4'hF;

    typedef logic [CLS_N-1:0] cls_vec_t;

    typedef struct packed {
        logic               vld;
        cls_vec_t           cls;
        logic               pass;
        logic               rsvd;
        logic               trap;
        logic [VAR_W-1:0]   vari;
    } dec_out_t;
endpackage

// File: rtl/ccd_cond_eval.sv
module ccd_cond_eval
    import ccd_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              pass_o,
    output logic              rsvd_o
);
    logic fn, fz, fc, fv;
    logic base;

    assign fn = flags_i[3];
    assign fz = flags_i[2];
    assign fc = flags_i[1];
    assign fv = flags_i[0];

    // Even codes test a predicate; the odd neighbour tests its complement.
    always_comb begin
        unique case (cond_i[3:1])
            3'd0:    base = fz;
            3'd1:    base = fc;
            3'd2:    base = fn;
            3'd3:    base = fv;
            3'd4:    base = fc & ~fz;
            3'd5:    base = (fn == fv);
            3'd6:    base = ~fz & (fn == fv);
            default: base = 1'b1;
        endcase
    end

    assign rsvd_o = (cond_i == COND_RSVD);
    assign pass_o = (cond_i[3:1] == 3'd7) ? ~cond_i[0] : (base ^ cond_i[0]);
endmodule

// File: rtl/ccd_class_match.sv
module ccd_class_match
    import ccd_pkg::*;
(
    input  logic [BODY_W-1:0] body_i,
    output cls_vec_t          cls_o,
    output logic [VAR_W-1:0]  vari_o
);
    logic bx_hit, swp_hit, mul_hit, mull_hit, gap_hit, hw_hit, low_rgn;
    cls_vec_t low_cls, up_cls;

    assign bx_hit   = (body_i[27:4] == 24'h12FFF1);
    assign swp_hit  = (body_i[27:23] == 5'b00010) && (body_i[21:20] == 2'b00)
                      && (body_i[11:4] == 8'h09);
    assign mul_hit  = (body_i[27:22] == 6'b000000) && (body_i[7:4] == 4'b1001);
    assign mull_hit = (body_i[27:23] == 5'b00001) && (body_i[7:4] == 4'b1001);
    assign gap_hit  = (body_i[27:24] == 4'b0000) && (body_i[7:4] == 4'b1101);
    assign hw_hit   = (body_i[27:25] == 3'b000) && body_i[7] && body_i[4]
                      && (body_i[22] || (body_i[11:8] == 4'b0000));
    assign low_rgn  = (body_i[27:26] == 2'b00);

    // Narrowest pattern first; the gap claims its words and emits nothing.
    always_comb begin
        low_cls = '0;
        if (bx_hit)        low_cls[CL_BX]   = 1'b1;
        else if (swp_hit)  low_cls[CL_SWAP] = 1'b1;
        else if (mul_hit)  low_cls[CL_MUL]  = 1'b1;
        else if (mull_hit) low_cls[CL_MULL] = 1'b1;
        else if (gap_hit)  low_cls          = '0;
        else if (hw_hit)   low_cls[CL_HALF] = 1'b1;
        else               low_cls[CL_DP]   = 1'b1;
    end

    always_comb begin
        up_cls = '0;
        unique case (body_i[27:25])
            3'b010:  up_cls[CL_SXFR] = 1'b1;
            3'b011:  begin
                if (body_i[4]) up_cls[CL_UNDEF] = 1'b1;
                else           up_cls[CL_SXFR]  = 1'b1;
            end
            3'b100:  up_cls[CL_BLK] = 1'b1;
            3'b101:  up_cls[CL_BR]  = 1'b1;
            3'b110:  up_cls[CL_CPX] = 1'b1;
            3'b111:  begin
                if (body_i[24])     up_cls[CL_SWI] = 1'b1;
                else if (body_i[4]) up_cls[CL_CPR] = 1'b1;
                else                up_cls[CL_CPD] = 1'b1;
            end
            default: up_cls = '0;
        endcase
    end

    assign cls_o = low_rgn ? low_cls : up_cls;

    always_comb begin
        vari_o = '0;
        if (cls_o[CL_HALF])      vari_o = {body_i[22], body_i[6], body_i[5]};
        else if (cls_o[CL_SWAP]) vari_o = {2'b00, body_i[22]};
        else if (cls_o[CL_BR])   vari_o = {2'b00, body_i[24]};
    end
endmodule

// File: rtl/cond_class_decode.sv
module cond_class_decode
    import ccd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              valid_o,
    output logic [CLS_N-1:0]  class_o,
    output logic              cond_pass_o,
    output logic              cond_rsvd_o,
    output logic              undef_trap_o,
    output logic [VAR_W-1:0]  variant_o
);
    logic             pass_w, rsvd_w;
    cls_vec_t         cls_w;
    logic [VAR_W-1:0] vari_w;
    dec_out_t         out_d, out_q;

    ccd_cond_eval u_cond (
        .cond_i  (insn_i[INSN_W-1 -: COND_W]),
        .flags_i (flags_i),
        .pass_o  (pass_w),
        .rsvd_o  (rsvd_w)
    );

    ccd_class_match u_match (
        .body_i (insn_i[BODY_W-1:0]),
        .cls_o  (cls_w),
        .vari_o (vari_w)
    );

    always_comb begin
        out_d = '0;
        if (valid_i) begin
            out_d.vld  = 1'b1;
            out_d.cls  = cls_w;
            out_d.pass = pass_w;
            out_d.rsvd = rsvd_w;
            out_d.trap = cls_w[CL_UNDEF] & pass_w;
            out_d.vari = vari_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign valid_o      = out_q.vld;
    assign class_o      = out_q.cls;
    assign cond_pass_o  = out_q.pass;
    assign cond_rsvd_o  = out_q.rsvd;
    assign undef_trap_o = out_q.trap;
    assign variant_o    = out_q.vari;
endmodule

// File: rtl/ccd_chk.sv
module ccd_chk
    import ccd_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [INSN_W-1:0] insn_i,
    input logic              valid_o,
    input logic [CLS_N-1:0]  class_o,
    input logic              cond_pass_o,
    input logic              cond_rsvd_o,
    input logic              undef_trap_o,
    input logic [VAR_W-1:0]  variant_o
);
    p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);

    p_idle_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);

    p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (class_o == '0 && !cond_pass_o && !cond_rsvd_o
                      && !undef_trap_o && variant_o == '0));

    p_rsvd_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (cond_rsvd_o == ($past(insn_i[31:28]) == 4'hF)));

    p_rsvd_nopass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cond_rsvd_o |-> !cond_pass_o);

    p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(class_o));

    p_bx_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && insn_i[27:4] == 24'h12FFF1) |=> class_o[CL_BX]);

    p_gap_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && insn_i[27:24] == 4'h0 && insn_i[7:4] == 4'hD)
        |=> (class_o == '0 && !undef_trap_o));

    p_trap_undef_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        undef_trap_o |-> (class_o[CL_UNDEF] && cond_pass_o));
endmodule

bind cond_class_decode ccd_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .insn_i       (insn_i),
    .valid_o      (valid_o),
    .class_o      (class_o),
    .cond_pass_o  (cond_pass_o),
    .cond_rsvd_o  (cond_rsvd_o),
    .undef_trap_o (undef_trap_o),
    .variant_o    (variant_o)
);

// File: tb/sim_cond_class_decode.sv
`timescale 1ns/1ps
module sim_cond_class_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [3:0]  flags_i = '0;
    logic        valid_o, cond_pass_o, cond_rsvd_o, undef_trap_o;
    logic [13:0] class_o;
    logic [2:0]  variant_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cond_class_decode u0 (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .insn_i(insn_i),
        .flags_i(flags_i), .valid_o(valid_o), .class_o(class_o),
        .cond_pass_o(cond_pass_o), .cond_rsvd_o(cond_rsvd_o),
        .undef_trap_o(undef_trap_o), .variant_o(variant_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R3 / R4: condition table
    function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'h0: return z;            4'h1: return !z;
            4'h2: return cy;           4'h3: return !cy;
            4'h4: return n;            4'h5: return !n;
            4'h6: return v;            4'h7: return !v;
            4'h8: return cy && !z;     4'h9: return !cy || z;
            4'hA: return n == v;       4'hB: return n != v;
            4'hC: return !z && n == v; 4'hD: return z || n != v;
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Class index per R5; priority per R6..R11; returns -1 for no class
    function automatic int ref_idx(input logic [31:0] w);
        casez (w[27:4])
            24'b0001_0010_1111_1111_1111_0001: return 4;  // R6
            24'b0001_0?00_????_????_0000_1001: return 3;  // R7 swap
            24'b0000_00??_????_????_????_1001: return 1;  // R7 multiply
            24'b0000_1???_????_????_????_1001: return 2;  // R7 multiply long
            24'b0000_????_????_????_????_1101: return -1; // R8 gap
            24'b000?_?1??_????_????_????_1??1: return 5;  // R9 immediate
            24'b000?_?0??_????_????_0000_1??1: return 5;  // R9 register
            24'b00??_????_????_????_????_????: return 0;  // R10
            24'b011?_????_????_????_????_???1: return 7;  // R11 undefined
            24'b01??_????_????_????_????_????: return 6;
            24'b100?_????_????_????_????_????: return 8;
            24'b101?_????_????_????_????_????: return 9;
            24'b110?_????_????_????_????_????: return 10;
            24'b1110_????_????_????_????_???0: return 11;
            24'b1110_????_????_????_????_???1: return 12;
            default:                           return 13;
        endcase
    endfunction

    function automatic string cls_tag(input int k);
        case (k)
            4: return "R6";
            1, 2, 3: return "R7";
            -1: return "R8";
            5: return "R9";
            0: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic v, input logic [31:0] w, input logic [3:0] f);
        int k;
        logic [13:0] ecls;
        logic ep;
        logic [2:0] ev;
        @(negedge clk);
        valid_i = v; insn_i = w; flags_i = f;
        @(negedge clk);
        chk("R1 valid", {31'd0, valid_o}, {31'd0, v});
        if (!v) begin
            chk("R2 idle", {14'd0, class_o, cond_pass_o, cond_rsvd_o, undef_trap_o, variant_o}, 32'd0);
        end else begin
            k = ref_idx(w);
            ecls = (k < 0) ? 14'd0 : (14'd1 << k);
            ep = ref_pass(w[31:28], f);
            ev = 3'd0;
            if (k == 5) ev = {w[22], w[6], w[5]};
            else if (k == 3 || k == 9) ev = {2'b00, (k == 3) ? w[22] : w[24]};
            chk(cls_tag(k), {18'd0, class_o}, {18'd0, ecls});
            chk("R5 onehot", {31'd0, $countones(class_o) <= 1}, 32'd1);
            chk("R3 pass", {31'd0, cond_pass_o}, {31'd0, ep});
            chk("R4 rsvd", {31'd0, cond_rsvd_o}, {31'd0, w[31:28] == 4'hF});
            chk("R12 trap", {31'd0, undef_trap_o}, {31'd0, (k == 7) && ep});
            chk("R13 variant", {29'd0, variant_o}, {29'd0, ev});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset", {17'd0, valid_o, class_o, undef_trap_o}, 32'd0);
        rst_n = 1'b1;

        // R3 R4: every condition code against every flag set (branch body)
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 16; f++)
                apply(1'b1, {c[3:0], 28'hA00_0000}, f[3:0]);

        apply(1'b0, 32'hE12F_FF11, 4'h0); // R2 idle after valid

        // R6..R11 near-exhaustive sweep of bits 27:20 x 7:4
        for (int fill = 0; fill < 3; fill++)
            for (int hi = 0; hi < 256; hi++)
                for (int lo = 0; lo < 16; lo++) begin
                    logic [31:0] w;
                    logic [11:0] mid;
                    logic [3:0]  rn;
                    mid = (fill == 0) ? 12'h000 : (fill == 1) ? 12'hFFF : 12'hA5C;
                    rn  = (fill == 0) ? 4'h0 : (fill == 1) ? 4'h5 : 4'hE;
                    w = {4'(hi + lo), hi[7:0], mid, lo[3:0], rn};
                    apply(1'b1, w, 4'(hi ^ (lo << 1)));
                    if (lo == 15 && hi[3:0] == 0) apply(1'b0, w, 4'h0); // R2
                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule